// File: doc/BRIEF.md
# Test Sequence Stream Checker

This block watches one or more incoming data streams, each qualified by a valid strobe, and confirms that every stream carries an unbroken test sequence. Software picks the sequence type and turns checking on through a small register window. The block then locks each stream onto its own first received word and predicts every later word locally. The sequence type is either a pseudo-random shift sequence or a binary counter.

An input word is wider than the sequence. Its upper bits must repeat the sequence bits cyclically, and they are checked as strictly as the low part. A status word gives software two facts. The first is whether any mismatch has been seen since checking was last switched on. The second is whether a result is available yet, which needs checking enabled and every stream locked.

Each stream runs its own lane state machine with three states:
- `LANE_OFF`: checking is disabled.
- `LANE_SEED`: the lane waits for its first word.
- `LANE_CHECK`: the lane compares every valid word.

The transitions are:
- *arm*: OFF to SEED, when enable is seen with no valid word.
- *arm-and-seed*: OFF to CHECK, when enable is seen together with a valid word.
- *seed*: SEED to CHECK, on the first valid word.
- *compare*: CHECK stays in CHECK, on every valid word.
- *drop*: SEED or CHECK to OFF, when enable is cleared.

Top module: `seq_stream_checker`

## Requirements
- R1: A register write to address 0 stores bit 0 as the check enable and bit 1 as the pattern select (0 = pseudo-random, 1 = counter). A read of address 0 returns those two bits, with all other bits zero. No other write changes them.
- R2: `reg_rdata` carries the read result in the cycle after `reg_rd` is high and is zero in every other cycle. Address 1 returns the status word: bit 0 is the error flag, bit 1 is the no-result flag, and the other bits are zero. An unmapped address reads as zero. A status read in the same cycle as a mismatching word returns the flag value from before that word.
- R3: The no-result flag is 1 while checking is disabled, and also while any stream has not yet received its first word since enable.
- R4: The first valid word of a stream after enable is taken as that stream's seed and is never compared. Its bits above the sequence width are ignored.
- R5: A valid word whose low SEQ_W bits differ from the predicted value sets the error flag.
- R6: Bit i of a word must equal bit (i mod SEQ_W) of the predicted value for every i up to DATA_W-1. A mismatch in those upper bits alone sets the error flag.
- R7: The error flag is sticky. Once set, it stays set through any number of later correct words until the checker is re-enabled.
- R8: The prediction advances once per valid word and is based on the predicted value, not on the received word. Cycles with valid low are neither compared nor counted.
- R9: The counter successor is v+1 modulo 2^SEQ_W. The pseudo-random successor is {v[SEQ_W-2:0], XNOR-reduction of (v & TAPS)}. A stream of the other pattern type sets the error flag.
- R10: Clearing the enable keeps the error flag readable and sets the no-result flag. Setting the enable again clears the error flag and restarts seeding.
- R11: Each stream seeds and is checked independently. A mismatch on any stream sets the shared error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, one cycle after `reg_rd` |
| in_valid | input | NUM_STREAMS | Per-stream word valid |
| in_data | input | NUM_STREAMS*DATA_W | Stream words, stream k at bits [k*DATA_W +: DATA_W] |

## Verification
A status read and a word compare can land in the same cycle. In that case the read result must show the flag as it stood before the compare. The bench provokes this by raising `reg_rd` for the status address in the same cycle that a word with a corrupted replicated bit is presented. It then expects bit 0 clear in that read and set in the next read. A second collision is between a register write that drops the enable and the sticky flag: the bench disables the checker after an error and expects both status bits set.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [1:0] {
        LANE_OFF   = 2'd0,
        LANE_SEED  = 2'd1,
        LANE_CHECK = 2'd2
    } lane_state_t;

    localparam int unsigned ADDR_CTRL = 0;
    localparam int unsigned ADDR_STAT = 1;

    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_SEL_BIT = 1;

    localparam int unsigned STAT_ERR_BIT   = 0;
    localparam int unsigned STAT_NORES_BIT = 1;

endpackage

// File: rtl/ssc_next_word.sv
module ssc_next_word #(
    parameter int unsigned    SEQ_W = 16,
    parameter logic [SEQ_W-1:0] TAPS = 16'hB400
) (
    input  logic [SEQ_W-1:0] cur_i,
    input  logic             cnt_sel_i,
    output logic [SEQ_W-1:0] nxt_o
);

    logic [SEQ_W-1:0] prbs_nxt;
    logic [SEQ_W-1:0] cnt_nxt;
    logic             fb;

    // feedback bit: XNOR reduction of the tapped bits
    assign fb       = ~^(cur_i & TAPS);
    assign prbs_nxt = {cur_i[SEQ_W-2:0], fb};
    assign cnt_nxt  = cur_i + {{(SEQ_W-1){1'b0}}, 1'b1};

    always_comb begin
        if (cnt_sel_i) nxt_o = cnt_nxt;
        else           nxt_o = prbs_nxt;
    end

endmodule

// File: rtl/ssc_lane.sv
module ssc_lane
    import ssc_pkg::*;
#(
    parameter int unsigned      SEQ_W  = 16,
    parameter int unsigned      DATA_W = 40,
    parameter logic [SEQ_W-1:0] TAPS   = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              cnt_sel_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              err_o,
    output logic              locked_o
);

    lane_state_t      state_q, state_d;
    logic [SEQ_W-1:0] expect_q, expect_d;
    logic             err_q, err_d;
    logic [SEQ_W-1:0] nxt_from_rx;
    logic [SEQ_W-1:0] nxt_from_exp;
    logic [DATA_W-1:0] exp_word;
    logic             mismatch;

    // successor of the received low part (used when seeding)
    ssc_next_word #(.SEQ_W(SEQ_W), .TAPS(TAPS)) u_nxt_rx (
        .cur_i     (data_i[SEQ_W-1:0]),
        .cnt_sel_i (cnt_sel_i),
        .nxt_o     (nxt_from_rx)
    );

    // successor of the local prediction (used while checking)
    ssc_next_word #(.SEQ_W(SEQ_W), .TAPS(TAPS)) u_nxt_exp (
        .cur_i     (expect_q),
        .cnt_sel_i (cnt_sel_i),
        .nxt_o     (nxt_from_exp)
    );

    // full-width expected word: sequence bits repeated cyclically
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_rep
        assign exp_word[gi] = expect_q[gi % SEQ_W];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= LANE_OFF;
            expect_q <= '0;
            err_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            expect_q <= expect_d;
            err_q    <= err_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        expect_d = expect_q;
        err_d    = err_q;
        mismatch = 1'b0;
        unique case (state_q)
            LANE_OFF: begin
                if (en_i) begin
                    err_d = 1'b0;
                    if (valid_i) begin
                        expect_d = nxt_from_rx;
                        state_d  = LANE_CHECK;
                    end else begin
                        state_d  = LANE_SEED;
                    end
                end
            end
            LANE_SEED: begin
                if (!en_i) begin
                    state_d = LANE_OFF;
                end else if (valid_i) begin
                    expect_d = nxt_from_rx;
                    state_d  = LANE_CHECK;
                end
            end
            LANE_CHECK: begin
                if (!en_i) begin
                    state_d = LANE_OFF;
                end else if (valid_i) begin
                    mismatch = (data_i != exp_word);
                    err_d    = err_q | mismatch;
                    expect_d = nxt_from_exp;
                end
            end
            default: state_d = LANE_OFF;
        endcase
    end

    assign err_o    = err_q;
    assign locked_o = (state_q == LANE_CHECK);

    // R4: a seeding word never raises the flag
    p_seed_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && valid_i && (state_q == LANE_SEED || state_q == LANE_OFF)) |=> !err_o);

    // R7: the flag cannot drop while the lane is checking
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LANE_CHECK && err_o) |=> err_o);

    // R8: no advance of the prediction without a valid word
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LANE_CHECK && !valid_i) |=> $stable(expect_q));

    // R10: re-arming always leaves the flag clear
    p_rearm_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LANE_OFF && en_i) |=> !err_o);

endmodule

// File: rtl/ssc_ctrl_regs.sv
module ssc_ctrl_regs
    import ssc_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              any_err_i,
    input  logic              all_locked_i,
    output logic              en_o,
    output logic              cnt_sel_o
);

    logic [1:0]       ctrl_q;
    logic [REG_W-1:0] rdata_q;
    logic [REG_W-1:0] rd_mux;
    logic             no_result;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 2'b00;
        end else if (reg_wr && reg_addr == ADDR_W'(ADDR_CTRL)) begin
            ctrl_q <= reg_wdata[1:0];
        end
    end

    assign en_o      = ctrl_q[CTRL_EN_BIT];
    assign cnt_sel_o = ctrl_q[CTRL_SEL_BIT];
    assign no_result = !en_o || !all_locked_i;

    always_comb begin
        rd_mux = '0;
        if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
            rd_mux[1:0] = ctrl_q;
        end else if (reg_addr == ADDR_W'(ADDR_STAT)) begin
            rd_mux[STAT_ERR_BIT]   = any_err_i;
            rd_mux[STAT_NORES_BIT] = no_result;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_mux;
        else             rdata_q <= '0;
    end

    assign reg_rdata = rdata_q;

    // R2: read data is zero unless a read was issued the cycle before
    p_rdata_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> (reg_rdata == '0));

    // R3: a status read while disabled reports no result
    p_nores_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(ADDR_STAT) && !en_o) |=> reg_rdata[STAT_NORES_BIT]);

    // R1: control bits change only through a write to address 0
    p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_W'(ADDR_CTRL)) |=> $stable(ctrl_q));

endmodule

// File: rtl/seq_stream_checker.sv
module seq_stream_checker
    import ssc_pkg::*;
#(
    parameter int unsigned      NUM_STREAMS = 2,
    parameter int unsigned      SEQ_W       = 16,
    parameter int unsigned      DATA_W      = 40,
    parameter logic [SEQ_W-1:0] TAPS        = 16'hB400,
    parameter int unsigned      ADDR_W      = 2,
    parameter int unsigned      REG_W       = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic                          reg_rd,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [REG_W-1:0]              reg_wdata,
    output logic [REG_W-1:0]              reg_rdata,
    input  logic [NUM_STREAMS-1:0]        in_valid,
    input  logic [NUM_STREAMS*DATA_W-1:0] in_data
);

    logic                   en;
    logic                   cnt_sel;
    logic [NUM_STREAMS-1:0] lane_err;
    logic [NUM_STREAMS-1:0] lane_locked;

    ssc_ctrl_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .any_err_i    (|lane_err),
        .all_locked_i (&lane_locked),
        .en_o         (en),
        .cnt_sel_o    (cnt_sel)
    );

    for (genvar gs = 0; gs < NUM_STREAMS; gs++) begin : g_lane
        ssc_lane #(.SEQ_W(SEQ_W), .DATA_W(DATA_W), .TAPS(TAPS)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (en),
            .cnt_sel_i (cnt_sel),
            .valid_i   (in_valid[gs]),
            .data_i    (in_data[gs*DATA_W +: DATA_W]),
            .err_o     (lane_err[gs]),
            .locked_o  (lane_locked[gs])
        );
    end

    // R11: any lane in error appears in the status on the next read
    p_err_visible_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(ADDR_STAT) && |lane_err)
            |=> reg_rdata[STAT_ERR_BIT]);

endmodule

// File: tb/seq_stream_checker_bench.sv
module seq_stream_checker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NS  = 2;
    localparam int SW  = 16;
    localparam int DW  = 40;
    localparam logic [SW-1:0] TP = 16'hB400;

    typedef struct packed {
        logic        rx_sel;
        logic        tx_sel;
        logic [15:0] seed;
        logic [7:0]  nwords;
        logic [7:0]  bad_idx;
        logic        bad_hi;
        logic        bad_strm;
        logic        exp_err;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 16'h0011, 8'd20, 8'hFF, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 16'h1234, 8'd20, 8'hFF, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b0, 16'h0011, 8'd12, 8'hFF, 1'b0, 1'b0, 1'b1},
        '{1'b0, 1'b1, 16'h1234, 8'd12, 8'hFF, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b1, 16'h0100, 8'd12, 8'd5,  1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b1, 16'h0100, 8'd12, 8'd5,  1'b1, 1'b1, 1'b1},
        '{1'b0, 1'b0, 16'h0ACE, 8'd12, 8'd1,  1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b1, 16'h0200, 8'd12, 8'd0,  1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 16'hFFFE, 8'd6,  8'hFF, 1'b0, 1'b0, 1'b0}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                reg_wr = 1'b0;
    logic                reg_rd = 1'b0;
    logic [1:0]          reg_addr = '0;
    logic [31:0]         reg_wdata = '0;
    logic [31:0]         reg_rdata;
    logic [NS-1:0]       in_valid = '0;
    logic [NS*DW-1:0]    in_data = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    seq_stream_checker #(.NUM_STREAMS(NS), .SEQ_W(SW), .DATA_W(DW), .TAPS(TP)) u_seq_stream_checker (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .in_valid  (in_valid),
        .in_data   (in_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [SW-1:0] nxt(input logic [SW-1:0] v, input logic sel);
        if (sel) return v + 16'd1;
        return {v[SW-2:0], ~^(v & TP)};
    endfunction

    function automatic logic [DW-1:0] rep(input logic [SW-1:0] v);
        logic [DW-1:0] r;
        for (int b = 0; b < DW; b++) r[b] = v[b % SW];
        return r;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic send(input logic [NS-1:0] v, input logic [DW-1:0] d0, input logic [DW-1:0] d1);
        @(negedge clk);
        in_valid = v; in_data = {d1, d0};
        @(negedge clk);
        in_valid = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = '0;
            in_data = {NS{40'hDEAD_BEEF_55}};
        end
    endtask

    initial begin
        logic [31:0] r;
        logic [SW-1:0] c0, c1;
        logic [DW-1:0] w0, w1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk(reg_rdata == 32'h0, "R2 reset rdata", reg_rdata, 32'h0);
        rd(2'd0, r); chk(r == 32'h0, "R1 reset ctrl", r, 32'h0);
        rd(2'd1, r); chk(r == 32'h2, "R3 reset status", r, 32'h2);

        // control readback masking, unmapped address
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, r); chk(r == 32'h3, "R1 ctrl readback", r, 32'h3);
        rd(2'd3, r); chk(r == 32'h0, "R2 unmapped read", r, 32'h0);
        wr(2'd0, 32'h0);

        // vector table: each entry re-enables, streams a sequence, reads status
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            logic [SW-1:0] cur;
            t = VECS[v];
            wr(2'd0, 32'h0);
            wr(2'd0, {30'd0, t.rx_sel, 1'b1});
            cur = t.seed;
            for (int i = 0; i < int'(t.nwords); i++) begin
                w0 = rep(cur); w1 = rep(cur);
                if (i == int'(t.bad_idx)) begin
                    if (t.bad_strm) w1[t.bad_hi ? DW-1 : 0] = ~w1[t.bad_hi ? DW-1 : 0];
                    else            w0[t.bad_hi ? DW-1 : 0] = ~w0[t.bad_hi ? DW-1 : 0];
                end
                send(2'b11, w0, w1);
                if (i % 3 == 2) idle(2);
                cur = nxt(cur, t.tx_sel);
            end
            rd(2'd1, r);
            // R4 R5 R6 R8 R9 per table entry
            chk(r == {30'd0, 1'b0, t.exp_err}, $sformatf("R5/R6/R9 vector %0d", v), r, {31'd0, t.exp_err});
        end

        // independent seeding per stream
        wr(2'd0, 32'h0);
        wr(2'd0, 32'h3);
        rd(2'd1, r); chk(r == 32'h2, "R3 enabled before seed", r, 32'h2);
        send(2'b01, rep(16'd100), '0);
        rd(2'd1, r); chk(r == 32'h2, "R11 one stream seeded", r, 32'h2);
        send(2'b10, '0, rep(16'd200));
        rd(2'd1, r); chk(r == 32'h0, "R11 both seeded", r, 32'h0);
        send(2'b11, rep(16'd101), rep(16'd201));
        idle(5);
        send(2'b11, rep(16'd102), rep(16'd202));
        rd(2'd1, r); chk(r == 32'h0, "R8 gaps ignored", r, 32'h0);

        // status read colliding with a bad upper-bit word
        w1 = rep(16'd203); w1[20] = ~w1[20];
        @(negedge clk);
        in_valid = 2'b11; in_data = {w1, rep(16'd103)};
        reg_rd = 1'b1; reg_addr = 2'd1;
        @(negedge clk);
        in_valid = '0; reg_rd = 1'b0;
        chk(reg_rdata == 32'h0, "R2 same-cycle read sees old flag", reg_rdata, 32'h0);
        rd(2'd1, r); chk(r == 32'h1, "R6 upper-bit error", r, 32'h1);

        // sticky through good words
        c0 = 16'd104; c1 = 16'd204;
        for (int i = 0; i < 10; i++) begin
            send(2'b11, rep(c0), rep(c1));
            c0 = c0 + 16'd1; c1 = c1 + 16'd1;
        end
        rd(2'd1, r); chk(r == 32'h1, "R7 sticky flag", r, 32'h1);

        // disable keeps flag, re-enable clears it
        wr(2'd0, 32'h2);
        rd(2'd1, r); chk(r == 32'h3, "R10 disabled keeps error", r, 32'h3);
        wr(2'd0, 32'h3);
        rd(2'd1, r); chk(r == 32'h2, "R10 re-enable clears", r, 32'h2);
        send(2'b11, rep(16'd7), rep(16'd9));
        send(2'b11, rep(16'd8), rep(16'd10));
        rd(2'd1, r); chk(r == 32'h0, "R10 reseeded clean", r, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule